// File: doc/BRIEF.md
# Shift-Add Multi-Tap FIR Filter

This block is a time-multiplexed FIR filter. Every accepted 8-bit signed sample replaces the slot of an N-entry ring that a rotating pointer marks as the oldest. The block then spends N cycles on the sum. In each cycle one buffered sample is paired with one coefficient. A shift-add multiplier forms the product, and the product is added to or subtracted from a signed running sum. When the last tap has been folded in, the result is presented together with a one-cycle valid strobe, and the pointer steps forward by one slot.

Coefficients are written through a small indexed port. Each coefficient is a sign-magnitude word: an 8-bit magnitude plus a separate sign flag. A negative tap is applied by subtracting its product, so the multiplier only ever handles magnitudes. The source watches the `busy` output and offers a sample only while it is low. While the filter is working, it discards both sample strobes and coefficient writes.

Top module: `fir_shift_add_top`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `busy`=0, `out_valid`=0, `out_data`=0. Reset also clears every ring slot, every coefficient and the ring pointer to 0.
- R2: An `in_valid` strobe is taken only when `busy` is 0. A strobe seen while `busy` is 1 changes neither the ring nor any later result.
- R3: Let p be the ring slot the accepted sample was written to. The result is the sum over k=0..N-1 of c[k]·ring[(p+k) mod N], where c[k] is the coefficient at index k. Samples are 8-bit two's complement.
- R4: The first sample after reset goes to slot 0. The pointer advances by one, modulo N, in the same clock edge that raises `out_valid`, and it does not change at any other time.
- R5: `coef_val[8]` is the sign (1 = negative) and `coef_val[7:0]` is the magnitude, 0..255. A negative tap subtracts magnitude·sample from the running sum.
- R6: The sample is accepted at edge E0. `busy` is then high for the N cycles after E0. `out_valid` rises at edge E0+N, stays high for exactly one cycle, and `busy` is low while it is high.
- R7: When `coef_we` is 1 and `busy` is 0, `coef_val` is stored at index `coef_idx`. A write offered while `busy` is 1 is discarded.
- R8: `out_data` is a signed word of 16+clog2(N) bits. It holds every full-scale result exactly, for example N taps of -255 against samples of -128 or 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 8 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | clog2(N) | Coefficient index |
| coef_val | input | 9 | Sign (bit 8) and magnitude (bits 7:0) |
| busy | output | 1 | High while a sum is in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16+clog2(N) | Signed filter result |

## Verification
A wrong ring pointer or a wrong tap index does not show up as a single bad value. It shows up as results that pair coefficients with the wrong samples, and the first result after the fault already differs from the model whenever the taps are all different. A sign error appears in the first result that uses a negative tap. A broken sequencer shows as an `out_valid` pulse that arrives on the wrong cycle, or as a `busy` window of the wrong length, on the very next accepted sample. The bench therefore checks the latency and the value of every result against a ring model that it keeps itself.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int DATA_W = 8;
    localparam int MAG_W  = 8;
    localparam int PROD_W = DATA_W + MAG_W;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } coef_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACC  = 1'b1
    } fir_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fir_sample_ring.sv
module fir_sample_ring
    import fir_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = idx_width(N)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic                     advance,
    input  logic [IDX_W-1:0]         rd_off,
    output logic signed [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]         head
);
    logic signed [DATA_W-1:0] slots [N];
    logic [IDX_W:0]           raw_idx;
    logic [IDX_W-1:0]         rd_idx;

    always_comb begin
        raw_idx = {1'b0, head} + {1'b0, rd_off};
        if (raw_idx >= (IDX_W+1)'(N)) begin
            raw_idx = raw_idx - (IDX_W+1)'(N);
        end
        rd_idx  = raw_idx[IDX_W-1:0];
        rd_data = slots[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head <= '0;
        end else if (advance) begin
            head <= (head == IDX_W'(N-1)) ? '0 : head + 1'b1;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && head == IDX_W'(g)) begin
                slots[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank
    import fir_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = idx_width(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  coef_t            wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output coef_t            rd_val
);
    coef_t bank [N];

    for (genvar g = 0; g < N; g++) begin : g_coef
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (we && wr_idx == IDX_W'(g)) begin
                bank[g] <= wr_val;
            end
        end
    end

    assign rd_val = bank[rd_idx];

endmodule

// File: rtl/fir_shift_add_mult.sv
module fir_shift_add_mult
    import fir_pkg::*;
(
    input  logic signed [DATA_W-1:0] sample,
    input  logic [MAG_W-1:0]         mag,
    output logic signed [PROD_W-1:0] product
);
    logic signed [PROD_W-1:0] ext;
    logic signed [PROD_W-1:0] terms [MAG_W];

    assign ext = PROD_W'(sample);

    for (genvar b = 0; b < MAG_W; b++) begin : g_term
        assign terms[b] = mag[b] ? (ext <<< b) : '0;
    end

    always_comb begin
        product = '0;
        for (int b = 0; b < MAG_W; b++) begin
            product = product + terms[b];
        end
    end

endmodule

// File: rtl/fir_shift_add_top.sv
module fir_shift_add_top
    import fir_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = idx_width(N),
    parameter int ACC_W = PROD_W + $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_sample,
    input  logic                    coef_we,
    input  logic [IDX_W-1:0]        coef_idx,
    input  logic [MAG_W:0]          coef_val,
    output logic                    busy,
    output logic                    out_valid,
    output logic [ACC_W-1:0]        out_data
);
    fir_state_e               state;
    logic [IDX_W-1:0]         tap;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_next;
    logic                     idle;
    logic                     last_tap;
    logic                     take;
    logic signed [DATA_W-1:0] tap_sample;
    coef_t                    tap_coef;
    logic signed [PROD_W-1:0] tap_prod;
    logic [IDX_W-1:0]         head;

    assign idle     = (state == ST_IDLE);
    assign busy     = !idle;
    assign take     = idle && in_valid;
    assign last_tap = (state == ST_ACC) && (tap == IDX_W'(N-1));

    fir_sample_ring #(.N(N), .IDX_W(IDX_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (take),
        .wr_data (in_sample),
        .advance (last_tap),
        .rd_off  (tap),
        .rd_data (tap_sample),
        .head    (head)
    );

    fir_coef_bank #(.N(N), .IDX_W(IDX_W)) u_coef (
        .clk    (clk),
        .rst    (rst),
        .we     (coef_we && idle),
        .wr_idx (coef_idx),
        .wr_val (coef_t'(coef_val)),
        .rd_idx (tap),
        .rd_val (tap_coef)
    );

    fir_shift_add_mult u_mult (
        .sample  (tap_sample),
        .mag     (tap_coef.mag),
        .product (tap_prod)
    );

    always_comb begin
        if (tap_coef.neg) begin
            acc_next = acc - ACC_W'(tap_prod);
        end else begin
            acc_next = acc + ACC_W'(tap_prod);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            tap       <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state <= ST_ACC;
                        tap   <= '0;
                        acc   <= '0;
                    end
                end
                ST_ACC: begin
                    acc <= acc_next;
                    if (last_tap) begin
                        out_data  <= acc_next;
                        out_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        tap <= tap + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fir_shift_add_checker.sv
module fir_shift_add_checker #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int ACC_W = 19
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             busy,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data,
    input logic [IDX_W-1:0] head
);
    int busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(N-1)) ? '0 : p + 1'b1;
    endfunction

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!busy && !out_valid && out_data == '0 && head == '0));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r6_not_busy_at_result: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !busy);

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (busy_run == N));

    a_r2_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_valid) |=> busy);

    a_r2_start_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_valid));

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (head == step($past(head))));

    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(head));

endmodule

bind fir_shift_add_top fir_shift_add_checker #(.N(N), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data),
    .head      (head)
);

// File: tb/test_fir_shift_add_top.sv
module test_fir_shift_add_top;
    localparam int N     = 8;
    localparam int IDX_W = $clog2(N);
    localparam int ACC_W = 16 + $clog2(N);
    localparam time CLK_P = 20ns;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [7:0]       in_sample = '0;
    logic             coef_we = 1'b0;
    logic [IDX_W-1:0] coef_idx = '0;
    logic [8:0]       coef_val = '0;
    logic             busy;
    logic             out_valid;
    logic [ACC_W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    int m_ring [N];
    int m_coef [N];
    int m_head;

    always #(CLK_P/2) clk = ~clk;

    fir_shift_add_top #(.N(N)) i_fir_shift_add_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
        .busy(busy), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_ring[i] = 0;
            m_coef[i] = 0;
        end
        m_head = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic write_coef(input int idx, input int value);
        @(negedge clk);
        coef_we  = 1'b1;
        coef_idx = IDX_W'(idx);
        coef_val = (value < 0) ? {1'b1, 8'(-value)} : {1'b0, 8'(value)};
        @(negedge clk);
        coef_we = 1'b0;
        m_coef[idx] = value;
    endtask

    // mode 0: plain, 1: extra sample strobes while busy, 2: coefficient write while busy
    task automatic send(input int s, input int mode, input string req);
        int exp_sum;
        int seen_at;
        int sv;
        sv = (s > 127) ? s - 256 : s;
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 8'(s);
        m_ring[m_head] = sv;
        exp_sum = 0;
        for (int k = 0; k < N; k++) begin
            exp_sum += m_coef[k] * m_ring[(m_head + k) % N];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R6 busy after accept"}, int'(busy), 1);
        if (mode == 1) begin
            in_valid  = 1'b1;
            in_sample = 8'(s ^ 8'h5A);
        end else if (mode == 2) begin
            coef_we  = 1'b1;
            coef_idx = '0;
            coef_val = 9'h1FF;
        end
        seen_at = -1;
        for (int i = 1; i <= N + 2; i++) begin
            @(negedge clk);
            if (i == 2) begin
                in_valid = 1'b0;
                coef_we  = 1'b0;
            end
            if (out_valid && seen_at < 0) begin
                seen_at = i;
                check({req, " R3 result"}, $signed(out_data), exp_sum);
                check({req, " R6 busy low at result"}, int'(busy), 0);
            end
        end
        check({req, " R6 latency"}, seen_at, N);
        m_head = (m_head + 1) % N;
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_data", int'(out_data), 0);
    endtask

    task automatic t_ring_order();
        for (int k = 0; k < N; k++) write_coef(k, k + 1);
        for (int i = 0; i < N + 3; i++) send((i * 37 + 11) % 256, 0, "R3 R4 ring order");
    endtask

    task automatic t_negative();
        write_coef(0, 159);
        write_coef(1, -53);
        write_coef(3, -255);
        write_coef(6, -1);
        for (int i = 0; i < 5; i++) send((i * 91 + 200) % 256, 0, "R5 negative taps");
    endtask

    task automatic t_busy_sample();
        send(77, 1, "R2 strobe while busy");
        send(3, 0, "R2 ring unchanged");
    endtask

    task automatic t_busy_coef();
        send(250, 2, "R7 write while busy");
        send(19, 0, "R7 coefficient unchanged");
        write_coef(0, -7);
        send(19, 0, "R7 idle write taken");
    endtask

    task automatic t_extremes();
        for (int k = 0; k < N; k++) write_coef(k, -255);
        for (int i = 0; i < N; i++) send(128, 0, "R8 full scale positive");
        for (int i = 0; i < N; i++) send(127, 0, "R8 full scale negative");
    endtask

    task automatic t_reset_clears();
        do_reset();
        t_reset();
        write_coef(0, 5);
        write_coef(1, 9);
        write_coef(N - 1, -3);
        send(40, 0, "R1 R4 ring cleared by reset");
        send(-6 & 255, 0, "R1 R4 second after reset");
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ring_order();
        t_negative();
        t_busy_sample();
        t_busy_coef();
        t_extremes();
        t_reset_clears();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule